// File: doc/BRIEF.md
# Split-Screen Sobel Edge Detector

This block takes a raster-scan video stream of 24-bit RGB pixels and returns a stream of the same geometry in which each line is split in two. Columns to the left of a split column carry a binary edge map: every pixel there is reduced to an 8-bit luma value, a 3x3 Sobel operator is evaluated around it, and the result is either pure white or pure black. Columns from the split column rightwards carry the input pixel unchanged, so one display shows the filtered and the raw picture side by side.

Two line memories keep the previous lines, and a 3x3 register window slides one column per pipeline step. The frame geometry is fixed by parameters, so the input needs no sideband markers. The output carries a start-of-frame flag and an end-of-line flag. Once the last input pixel of a frame has been taken, the block drains its own pipeline for one line plus three steps without further input, and it accepts no input until the frame's final output has been produced. Downstream back-pressure stalls the whole pipeline.

Top module: `sobel_split`

## Requirements
- R1: The luma of a pixel is (R + 2G + B) / 4, rounded down, where R is taken from bits 23:16, G from bits 15:8 and B from bits 7:0.
- R2: Horizontal gradient = (sum of the right column) - (sum of the left column), and vertical gradient = (sum of the bottom row) - (sum of the top row). Each sum weights the middle element by 2. The magnitude is |Gx| + |Gy| and is exact up to its maximum of 2040.
- R3: For an interior pixel of the left region, the output is 24'hFFFFFF when the magnitude is strictly greater than `edge_thresh` and 24'h000000 otherwise.
- R4: Left-region pixels in row 0, in the last row, in column 0 and in column SPLIT_COL-1 are output as 24'h000000 whatever the image content.
- R5: Pixels in columns SPLIT_COL and above are output equal to the input pixel at the same position.
- R6: Each frame yields exactly IMG_W*IMG_H output beats in raster order. `m_tuser` is high only on the first beat, and `m_tlast` is high exactly on column IMG_W-1.
- R7: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata`, `m_tuser` and `m_tlast` hold their values.
- R8: After the last input pixel of a frame, every remaining output of that frame is produced without further input, and `s_tready` stays low until the frame's last beat has been loaded.
- R9: Out of reset, `m_tvalid` is low and `s_tready` is high.
- R10: Frames sent back to back are each processed correctly, independent of the content of the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| edge_thresh | input | 11 | Magnitude threshold for the edge decision |
| s_tdata | input | 24 | Input pixel, R/G/B in bits 23:16/15:8/7:0 |
| s_tvalid | input | 1 | Input pixel valid |
| s_tready | output | 1 | Block accepts an input pixel |
| m_tdata | output | 24 | Output pixel |
| m_tvalid | output | 1 | Output pixel valid |
| m_tready | input | 1 | Downstream accepts the output pixel |
| m_tuser | output | 1 | First pixel of the frame |
| m_tlast | output | 1 | Last pixel of a line |

## Verification
A column counter or a line-memory address that is off by one shows up in the first processed line. The 1020-valued vertical step lands in the wrong column, and the raw right-half pixels come out shifted, so the error is visible within IMG_W+3 beats of the first output. A fault in the pipeline's step counting either loses or adds beats, and the flags then move away from columns 0 and IMG_W-1 at the next line end. A stall fault changes the held data under back-pressure within one cycle. Equality at the threshold is tested from both sides to catch a wrong comparison operator.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  localparam int PIX_W  = 24;
  localparam int LUMA_W = 8;
  localparam int MAG_W  = 11;

  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [LUMA_W-1:0] luma_t;
  typedef logic [MAG_W-1:0]  mag_t;

  localparam pix_t PIX_WHITE = 24'hFFFFFF;
  localparam pix_t PIX_BLACK = 24'h000000;

  // (R + 2G + B) >> 2 with shifts and adds only
  function automatic luma_t rgb_to_luma(input pix_t px);
    logic [9:0] acc;
    acc = {2'b00, px[23:16]} + {1'b0, px[15:8], 1'b0} + {2'b00, px[7:0]};
    return acc[9:2];
  endfunction
endpackage

// File: rtl/ssd_linebuf.sv
module ssd_linebuf #(
  parameter int DEPTH = 1280,
  parameter int DW    = 24,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  // registered read, read-before-write on a shared address
  always_ff @(posedge clk) begin
    if (en) begin
      rd_data      <= mem[rd_addr];
      mem[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/ssd_kernel.sv
module ssd_kernel
  import ssd_pkg::*;
(
  input  logic [2:0][2:0][LUMA_W-1:0] win,  // [row][col], row 0 oldest line, col 0 oldest column
  output mag_t                        mag
);
  function automatic logic [9:0] wsum(input luma_t a, input luma_t b, input luma_t c);
    return {2'b00, a} + {1'b0, b, 1'b0} + {2'b00, c};
  endfunction

  logic [9:0]         col_l, col_r, row_t, row_b;
  logic signed [10:0] gx, gy;
  logic [9:0]         ax, ay;

  always_comb begin
    col_l = wsum(win[0][0], win[1][0], win[2][0]);
    col_r = wsum(win[0][2], win[1][2], win[2][2]);
    row_t = wsum(win[0][0], win[0][1], win[0][2]);
    row_b = wsum(win[2][0], win[2][1], win[2][2]);
    gx = $signed({1'b0, col_r}) - $signed({1'b0, col_l});
    gy = $signed({1'b0, row_b}) - $signed({1'b0, row_t});
    ax = gx[10] ? 10'(-gx) : gx[9:0];
    ay = gy[10] ? 10'(-gy) : gy[9:0];
    mag = {1'b0, ax} + {1'b0, ay};
  end
endmodule

// File: rtl/sobel_split.sv
module sobel_split
  import ssd_pkg::*;
#(
  parameter int IMG_W     = 1280,
  parameter int IMG_H     = 720,
  parameter int SPLIT_COL = 640
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MAG_W-1:0] edge_thresh,
  input  logic [PIX_W-1:0] s_tdata,
  input  logic             s_tvalid,
  output logic             s_tready,
  output logic [PIX_W-1:0] m_tdata,
  output logic             m_tvalid,
  input  logic             m_tready,
  output logic             m_tuser,
  output logic             m_tlast
);
  localparam int NPIX      = IMG_W * IMG_H;
  localparam int TAIL      = IMG_W + 3;          // steps between a head pixel and its output
  localparam int LAST_STEP = NPIX + TAIL - 1;
  localparam int STEP_W    = $clog2(LAST_STEP + 1);
  localparam int COL_W     = $clog2(IMG_W);
  localparam int ROW_W     = $clog2(IMG_H);

  localparam logic [STEP_W-1:0] STEP_LAST  = STEP_W'(LAST_STEP);
  localparam logic [STEP_W-1:0] STEP_INEND = STEP_W'(NPIX - 1);
  localparam logic [STEP_W-1:0] STEP_FIRST = STEP_W'(TAIL);
  localparam logic [COL_W-1:0]  COL_END    = COL_W'(IMG_W - 1);
  localparam logic [COL_W-1:0]  COL_SPLIT  = COL_W'(SPLIT_COL);
  localparam logic [COL_W-1:0]  COL_LBORD  = COL_W'(SPLIT_COL - 1);
  localparam logic [ROW_W-1:0]  ROW_END    = ROW_W'(IMG_H - 1);

  // ---------------- step control ----------------
  logic [STEP_W-1:0] step;
  logic              draining;
  logic [COL_W-1:0]  head_col, head_col_q;
  logic              out_free, adv, out_load;
  pix_t              head_px;

  assign out_free = !m_tvalid || m_tready;
  assign s_tready = !draining && out_free;
  assign adv      = out_free && (draining || s_tvalid);
  assign out_load = adv && (step >= STEP_FIRST);
  assign head_px  = draining ? PIX_BLACK : s_tdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      step       <= '0;
      draining   <= 1'b0;
      head_col   <= '0;
      head_col_q <= '0;
    end else if (adv) begin
      head_col   <= (head_col == COL_END) ? '0 : head_col + COL_W'(1);
      head_col_q <= head_col;
      if (step == STEP_LAST) begin
        step     <= '0;
        draining <= 1'b0;
      end else begin
        step <= step + STEP_W'(1);
        if (step == STEP_INEND) draining <= 1'b1;
      end
    end
  end

  // ---------------- line memories ----------------
  pix_t  mid_px_q;
  luma_t top_luma_q, bot_luma_q;

  ssd_linebuf #(.DEPTH(IMG_W), .DW(PIX_W)) u_lb_rgb (
    .clk     (clk),
    .en      (adv),
    .rd_addr (head_col),
    .wr_addr (head_col),
    .wr_data (head_px),
    .rd_data (mid_px_q)
  );

  ssd_linebuf #(.DEPTH(IMG_W), .DW(LUMA_W)) u_lb_luma (
    .clk     (clk),
    .en      (adv),
    .rd_addr (head_col),
    .wr_addr (head_col_q),
    .wr_data (rgb_to_luma(mid_px_q)),
    .rd_data (top_luma_q)
  );

  always_ff @(posedge clk) begin
    if (adv) bot_luma_q <= rgb_to_luma(head_px);
  end

  // ---------------- sliding window ----------------
  logic [2:0][2:0][LUMA_W-1:0] win;
  logic [2:0][LUMA_W-1:0]      col_in;
  pix_t                        ctr_d1, ctr_d2;
  mag_t                        mag;

  assign col_in[0] = top_luma_q;
  assign col_in[1] = rgb_to_luma(mid_px_q);
  assign col_in[2] = bot_luma_q;

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int r = 0; r < 3; r++) begin
        win[r][0] <= win[r][1];
        win[r][1] <= win[r][2];
        win[r][2] <= col_in[r];
      end
      ctr_d1 <= mid_px_q;
      ctr_d2 <= ctr_d1;
    end
  end

  ssd_kernel u_kernel (
    .win (win),
    .mag (mag)
  );

  // ---------------- output stage ----------------
  logic [COL_W-1:0] ocol;
  logic [ROW_W-1:0] orow;
  logic             in_right, on_border;
  pix_t             out_px;

  always_comb begin
    in_right  = (ocol >= COL_SPLIT);
    on_border = (orow == '0) || (orow == ROW_END) || (ocol == '0) || (ocol == COL_LBORD);
    if (in_right)          out_px = ctr_d2;
    else if (on_border)    out_px = PIX_BLACK;
    else if (mag > edge_thresh) out_px = PIX_WHITE;
    else                   out_px = PIX_BLACK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_tvalid <= 1'b0;
      m_tdata  <= PIX_BLACK;
      m_tuser  <= 1'b0;
      m_tlast  <= 1'b0;
      ocol     <= '0;
      orow     <= '0;
    end else if (adv) begin
      m_tvalid <= out_load;
      if (out_load) begin
        m_tdata <= out_px;
        m_tuser <= (ocol == '0) && (orow == '0);
        m_tlast <= (ocol == COL_END);
        if (ocol == COL_END) begin
          ocol <= '0;
          orow <= (orow == ROW_END) ? '0 : orow + ROW_W'(1);
        end else begin
          ocol <= ocol + COL_W'(1);
        end
      end
    end else if (m_tready) begin
      m_tvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/ssd_checker.sv
module ssd_checker
  import ssd_pkg::*;
#(
  parameter int IMG_W     = 1280,
  parameter int IMG_H     = 720,
  parameter int SPLIT_COL = 640
) (
  input logic             clk,
  input logic             rst,
  input logic [PIX_W-1:0] m_tdata,
  input logic             m_tvalid,
  input logic             m_tready,
  input logic             m_tuser,
  input logic             m_tlast
);
  localparam int COL_W = $clog2(IMG_W);
  localparam int ROW_W = $clog2(IMG_H);

  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic             left, border;

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0;
      row <= '0;
    end else if (m_tvalid && m_tready) begin
      if (col == COL_W'(IMG_W - 1)) begin
        col <= '0;
        row <= (row == ROW_W'(IMG_H - 1)) ? '0 : row + ROW_W'(1);
      end else begin
        col <= col + COL_W'(1);
      end
    end
  end

  assign left   = col < COL_W'(SPLIT_COL);
  assign border = (col == '0) || (col == COL_W'(SPLIT_COL - 1)) ||
                  (row == '0) || (row == ROW_W'(IMG_H - 1));

  a_r9_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !m_tvalid);

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast)));

  a_r3_binary_left: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && left) |-> (m_tdata == PIX_WHITE || m_tdata == PIX_BLACK));

  a_r4_border_black: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && left && border) |-> (m_tdata == PIX_BLACK));

  a_r6_line_end: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> (m_tlast == (col == COL_W'(IMG_W - 1))));

  a_r6_frame_start: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> (m_tuser == (col == '0 && row == '0)));
endmodule

bind sobel_split ssd_checker #(
  .IMG_W     (IMG_W),
  .IMG_H     (IMG_H),
  .SPLIT_COL (SPLIT_COL)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .m_tdata  (m_tdata),
  .m_tvalid (m_tvalid),
  .m_tready (m_tready),
  .m_tuser  (m_tuser),
  .m_tlast  (m_tlast)
);

// File: tb/sobel_split_tb.sv
module sobel_split_tb;
  localparam int W   = 16;
  localparam int H   = 6;
  localparam int SPL = 8;
  localparam int N   = W * H;
  localparam int NCASE = 5;
  // {pattern[3:0], backpressure, threshold[10:0]}
  localparam logic [15:0] CASES [NCASE] = '{
    {4'd0, 1'b0, 11'd1020},
    {4'd0, 1'b0, 11'd1019},
    {4'd1, 1'b1, 11'd200},
    {4'd2, 1'b1, 11'd60},
    {4'd1, 1'b0, 11'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] thr = '0;
  logic [23:0] s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tready;
  logic [23:0] m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1'b1;
  logic        m_tuser, m_tlast;

  int total = 0;
  int bad   = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [23:0] img  [N];
  logic [23:0] expv [N];
  logic [23:0] cap  [N];

  always #5 clk = ~clk;

  sobel_split #(.IMG_W(W), .IMG_H(H), .SPLIT_COL(SPL)) u_dut (
    .clk (clk), .rst (rst), .edge_thresh (thr),
    .s_tdata (s_tdata), .s_tvalid (s_tvalid), .s_tready (s_tready),
    .m_tdata (m_tdata), .m_tvalid (m_tvalid), .m_tready (m_tready),
    .m_tuser (m_tuser), .m_tlast (m_tlast)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int luma(input logic [23:0] p);
    return (int'(p[23:16]) + 2 * int'(p[15:8]) + int'(p[7:0])) / 4;  // R1
  endfunction

  function automatic logic [23:0] pattern(input int pat, input int r, input int c);
    int i;
    i = r * W + c;
    case (pat)
      0:       return (c >= 4) ? 24'hFFFFFF : 24'h000000;
      1:       return {8'(i * 37 + 11), 8'(i * 91 + 5), 8'(i * 53 + 200)};
      default: return {8'(r * 40), 8'(c * 15), 8'((r + c) * 9)};
    endcase
  endfunction

  task automatic build(input int pat, input int t);
    int lu [N];
    int gx, gy, mag;
    for (int i = 0; i < N; i++) begin
      img[i] = pattern(pat, i / W, i % W);
      lu[i]  = luma(img[i]);
    end
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        if (c >= SPL) expv[r*W+c] = img[r*W+c];
        else if (r == 0 || r == H-1 || c == 0 || c == SPL-1) expv[r*W+c] = 24'h0;
        else begin
          gx = (lu[(r-1)*W+c+1] + 2*lu[r*W+c+1] + lu[(r+1)*W+c+1])
             - (lu[(r-1)*W+c-1] + 2*lu[r*W+c-1] + lu[(r+1)*W+c-1]);
          gy = (lu[(r+1)*W+c-1] + 2*lu[(r+1)*W+c] + lu[(r+1)*W+c+1])
             - (lu[(r-1)*W+c-1] + 2*lu[(r-1)*W+c] + lu[(r-1)*W+c+1]);
          mag = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);   // R2
          expv[r*W+c] = (mag > t) ? 24'hFFFFFF : 24'h0;
        end
      end
    end
  endtask

  task automatic run_frame(input bit bp, input int fidx);
    int sent, got, bad0;
    bit fired, drain_bad, stall_seen;
    logic [25:0] held;
    string tag;
    sent = 0; got = 0; fired = 0; drain_bad = 0; stall_seen = 0; held = '0;
    bad0 = bad;
    while (got < N) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (stall_seen)  // R7: stalled beat unchanged one cycle later
        check(m_tvalid && {m_tdata, m_tuser, m_tlast} == held, "R7 hold under stall",
              {7'd0, m_tvalid, m_tdata}, {8'd1, held[25:2]});
      m_tready = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
      if (!s_tvalid || fired) s_tvalid = (sent < N) && (bp ? lfsr[5] : 1'b1);
      s_tdata = (sent < N) ? img[sent] : 24'h0;
      #1;
      fired = s_tvalid && s_tready;
      stall_seen = m_tvalid && !m_tready;
      held = {m_tdata, m_tuser, m_tlast};
      if (sent == N && got < N - 1 && s_tready) drain_bad = 1;
      if (m_tvalid && m_tready) begin
        int r, c;
        r = got / W; c = got % W;
        if (c >= SPL)                                    tag = "R5 passthrough";
        else if (r == 0 || r == H-1 || c == 0 || c == SPL-1) tag = "R4 border";
        else                                             tag = "R1,R2,R3 interior";
        check(m_tdata == expv[got], tag, {8'd0, m_tdata}, {8'd0, expv[got]});
        check(m_tuser == (got == 0), "R6 start flag", {31'd0, m_tuser}, {31'd0, got == 0});
        check(m_tlast == (c == W-1), "R6 line-end flag", {31'd0, m_tlast}, {31'd0, c == W-1});
        cap[got] = m_tdata;
        got++;
      end
      if (fired) sent++;
    end
    @(negedge clk);
    s_tvalid = 1'b0;
    m_tready = 1'b1;
    check(!drain_bad, "R8 input held off while draining", {31'd0, drain_bad}, 32'd0);
    check(sent == N, "R8 all input taken", sent, N);
    if (fidx > 0) check(bad == bad0, "R10 back-to-back frame clean", bad - bad0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R6 watchdog act=hung exp=all frames done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(!m_tvalid, "R9 reset valid low", {31'd0, m_tvalid}, 32'd0);
    check(s_tready, "R9 reset ready high", {31'd0, s_tready}, 32'd1);

    for (int k = 0; k < NCASE; k++) begin
      thr = CASES[k][10:0];
      build(int'(CASES[k][15:12]), int'(CASES[k][10:0]));
      run_frame(CASES[k][11], k);
      // R3 directed: magnitude of exactly 1020 at (2,3) and (2,4)
      if (k == 0) begin
        check(cap[2*W+3] == 24'h0, "R3 equal to threshold is black", {8'd0, cap[2*W+3]}, 32'h0);
        check(cap[2*W+4] == 24'h0, "R3 equal to threshold is black", {8'd0, cap[2*W+4]}, 32'h0);
      end
      if (k == 1) begin
        check(cap[2*W+3] == 24'hFFFFFF, "R3 one above threshold is white", {8'd0, cap[2*W+3]}, 32'hFFFFFF);
        check(cap[2*W+4] == 24'hFFFFFF, "R3 one above threshold is white", {8'd0, cap[2*W+4]}, 32'hFFFFFF);
      end
    end
    // R4 directed: column SPL-1 of an interior row is black even across an edge
    check(cap[3*W+SPL-1] == 24'h0, "R4 split-side border column", {8'd0, cap[3*W+SPL-1]}, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule